// File: doc/BRIEF.md
# Dual-Order Burst Address Sequencer

This block produces the burst address for a four-beat memory burst. When a burst begins, the block captures a full start address. On every clock edge where advance is asserted, it steps the low offset bits through the four beats of the burst. The upper address bits are held at the captured value for the whole burst and are never changed by stepping. Only the low offset field moves.

A static order input chooses how the offset walks through the four beats:
- **Linear order:** the offset counts up by one and wraps modulo four.
- **Interleaved order:** the offset is the start offset XOR the beat number.

A low level on the order input selects linear order. A high level selects interleaved order. A pin that is not driven to a known low also gives interleaved order. A last-beat flag marks the fourth beat so that the bus side knows when the burst ends. A load that comes after the fourth beat starts a new burst. Advancing past the fourth beat wraps the sequence back to the first beat.

Top module: `burst_seq`

## Requirements
- R1: After reset, `addr_o` is all zeros and `last_o` is low, until the first load or advance.
- R2: After a clock edge where `load_i` is high, `addr_o` equals the `start_addr_i` value sampled at that edge, and `last_o` is low.
- R3: When `load_i` and `adv_i` are both high at the same edge, the load wins. The output shows the new start value as the first beat, and the beat count restarts at zero.
- R4: At an edge where both `load_i` and `adv_i` are low, `addr_o` and `last_o` keep their values, provided `order_sel_i` does not change.
- R5: With `order_sel_i` low (linear), each advance makes `addr_o[1:0]` the previous value plus one, modulo 4. For example, a start of 2'b10 gives 10, 11, 00, 01.
- R6: With `order_sel_i` high (interleaved), beat k (k = 0..3) has `addr_o[1:0]` equal to the start offset XOR k. For example, a start of 2'b11 gives 11, 10, 01, 00.
- R7: In both orders, the four beats after a load cover each of the values 00, 01, 10 and 11 exactly once.
- R8: `last_o` is high exactly while the beat count since the last load is 3, that is, on the fourth beat.
- R9: An advance on the fourth beat returns `addr_o` to the start offset and clears `last_o`.
- R10: `addr_o[15:2]` equals the upper bits of the last loaded address. Neither advances nor changes on `start_addr_i` without a load alter these bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Capture `start_addr_i` and begin a burst |
| adv_i | input | 1 | Step to the next beat |
| start_addr_i | input | 16 | Start address of the burst |
| order_sel_i | input | 1 | 0 = linear order; 1 or undriven = interleaved order |
| addr_o | output | 16 | Current burst address |
| last_o | output | 1 | High on the fourth beat |

## Verification
The hardest case to reach from the ports is a load that arrives together with an advance while the burst is already on its fourth beat. To reach it, the stimulus first walks a burst up to its last beat. It then raises both controls at the same edge and checks that the new start appears with the last-beat flag cleared. Every start offset is also driven in both orders, and each burst is advanced past its fourth beat, so that the wrap back to the start value is seen for all eight order and offset combinations.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   // How the beat order is chosen: from the pin, or fixed at build time.
   typedef enum logic [1:0] {
      ORD_PIN        = 2'd0,
      ORD_LINEAR     = 2'd1,
      ORD_INTERLEAVE = 2'd2
   } order_cfg_e;

endpackage

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
   parameter int unsigned CNT_W = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             step_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             at_end_o
);

   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] CNT_LAST = '1;

   logic [CNT_W-1:0] cnt_q;

   // Clear has priority over step; the count wraps naturally at its width.
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (step_i) begin
         cnt_q <= cnt_q + CNT_ONE;
      end
   end

   assign cnt_o    = cnt_q;
   assign at_end_o = (cnt_q == CNT_LAST);

endmodule

// File: rtl/bseq_base_reg.sv
module bseq_base_reg #(
   parameter int unsigned ADDR_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] start_i,
   output logic [ADDR_W-1:0] base_o
);

   logic [ADDR_W-1:0] base_q;

   // Captures the whole start address once per burst.
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         base_q <= '0;
      end else if (load_i) begin
         base_q <= start_i;
      end
   end

   assign base_o = base_q;

endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map
   import burst_seq_pkg::*;
#(
   parameter int unsigned OFS_W = 2,
   parameter order_cfg_e  CFG   = ORD_PIN
) (
   input  logic [OFS_W-1:0] base_ofs_i,
   input  logic [OFS_W-1:0] beat_i,
   input  logic             sel_i,
   output logic [OFS_W-1:0] ofs_o
);

   logic [OFS_W-1:0] lin_ofs;
   logic [OFS_W-1:0] xor_ofs;

   // Linear order adds the beat number modulo 2**OFS_W.
   // Interleaved order flips bits of the start offset by the beat number.
   assign lin_ofs = base_ofs_i + beat_i;
   assign xor_ofs = base_ofs_i ^ beat_i;

   generate
      if (CFG == ORD_LINEAR) begin : g_lin
         assign ofs_o = lin_ofs;
      end else if (CFG == ORD_INTERLEAVE) begin : g_xor
         assign ofs_o = xor_ofs;
      end else begin : g_pin
         // Only a known low selects linear; high or undriven gives interleave.
         logic use_xor;
         assign use_xor = (sel_i !== 1'b0);
         assign ofs_o   = use_xor ? xor_ofs : lin_ofs;
      end
   endgenerate

endmodule

// File: rtl/burst_seq.sv
module burst_seq
   import burst_seq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned BEAT_W    = 2,
   parameter order_cfg_e  ORDER_CFG = ORD_PIN
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic              adv_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic              order_sel_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              last_o
);

   localparam int unsigned UP_W = ADDR_W - BEAT_W;

   generate
      if (BEAT_W < 1) begin : g_bad_beat
         $error("burst_seq: BEAT_W must be at least 1");
      end
      if (ADDR_W <= BEAT_W) begin : g_bad_addr
         $error("burst_seq: ADDR_W must exceed BEAT_W");
      end
   endgenerate

   logic [ADDR_W-1:0] base_addr;
   logic [BEAT_W-1:0] beat_cnt;
   logic [BEAT_W-1:0] cur_ofs;
   logic              beat_end;

   bseq_base_reg #(
      .ADDR_W (ADDR_W)
   ) u_base (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load_i),
      .start_i (start_addr_i),
      .base_o  (base_addr)
   );

   // A load clears the count, so an advance in the same cycle is ignored.
   bseq_beat_ctr #(
      .CNT_W (BEAT_W)
   ) u_ctr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (load_i),
      .step_i   (adv_i),
      .cnt_o    (beat_cnt),
      .at_end_o (beat_end)
   );

   bseq_order_map #(
      .OFS_W (BEAT_W),
      .CFG   (ORDER_CFG)
   ) u_map (
      .base_ofs_i (base_addr[BEAT_W-1:0]),
      .beat_i     (beat_cnt),
      .sel_i      (order_sel_i),
      .ofs_o      (cur_ofs)
   );

   assign addr_o = {base_addr[ADDR_W-1 -: UP_W], cur_ofs};
   assign last_o = beat_end;

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned BEAT_W = 2
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              load_i,
   input logic              adv_i,
   input logic [ADDR_W-1:0] start_addr_i,
   input logic              order_sel_i,
   input logic [ADDR_W-1:0] addr_o,
   input logic              last_o
);

   AST_LOAD_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> (addr_o == $past(start_addr_i)) && !last_o); // R2

   AST_LOAD_BEATS_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && adv_i) |=> (addr_o[BEAT_W-1:0] == $past(start_addr_i[BEAT_W-1:0]))); // R3

   AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && !adv_i) ##1 $stable(order_sel_i) |-> $stable(addr_o) && $stable(last_o)); // R4

   AST_LINEAR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && adv_i && (order_sel_i === 1'b0)) ##1 (order_sel_i === 1'b0)
      |-> addr_o[BEAT_W-1:0] == BEAT_W'($past(addr_o[BEAT_W-1:0]) + 1'b1)); // R5

   AST_LAST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (last_o && adv_i && !load_i) |=> !last_o); // R9

   AST_UPPER_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> $stable(addr_o[ADDR_W-1:BEAT_W])); // R10

endmodule

bind burst_seq burst_seq_chk #(
   .ADDR_W (ADDR_W),
   .BEAT_W (BEAT_W)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .load_i       (load_i),
   .adv_i        (adv_i),
   .start_addr_i (start_addr_i),
   .order_sel_i  (order_sel_i),
   .addr_o       (addr_o),
   .last_o       (last_o)
);

// File: tb/burst_seq_test.sv
module burst_seq_test;

   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_ni;
   logic          load_i;
   logic          adv_i;
   logic [AW-1:0] start_addr_i;
   logic          order_sel_i;
   logic [AW-1:0] addr_o;
   logic          last_o;

   always #4 clk = ~clk;

   burst_seq uut (
      .clk_i        (clk),
      .rst_ni       (rst_ni),
      .load_i       (load_i),
      .adv_i        (adv_i),
      .start_addr_i (start_addr_i),
      .order_sel_i  (order_sel_i),
      .addr_o       (addr_o),
      .last_o       (last_o)
   );

   typedef struct {
      logic [AW-1:0] addr;
      logic          last;
      string         tag;
   } exp_t;

   exp_t          sb_q[$];
   int            checks = 0;
   int            errors = 0;
   bit            done   = 1'b0;

   // Reference model state, kept from the requirements only.
   logic [AW-1:0] m_start = '0;
   int            m_cnt   = 0;

   task automatic drive(input logic ld, input logic av, input logic [AW-1:0] st,
                        input logic md, input string tag);
      exp_t       e;
      logic [1:0] k;
      @(negedge clk);
      load_i       = ld;
      adv_i        = av;
      start_addr_i = st;
      order_sel_i  = md;
      if (ld) begin
         m_start = st;
         m_cnt   = 0;
      end else if (av) begin
         m_cnt = (m_cnt + 1) % 4;
      end
      k      = 2'(m_cnt);
      e.addr = {m_start[AW-1:2], md ? (m_start[1:0] ^ k) : (m_start[1:0] + k)};
      e.last = (m_cnt == 3);
      e.tag  = tag;
      sb_q.push_back(e);
   endtask

   // Monitor: samples 2 ns after each rising edge.
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #2;
         if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            checks++;
            if (addr_o !== e.addr || last_o !== e.last) begin
               errors++;
               $display("FAIL %s: addr=%h last=%b expected addr=%h last=%b",
                        e.tag, addr_o, last_o, e.addr, e.last);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_ni       = 1'b0;
      load_i       = 1'b0;
      adv_i        = 1'b0;
      start_addr_i = '0;
      order_sel_i  = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_ni = 1'b1;

      drive(0, 0, 16'h0000, 1, "R1 reset state");

      // Linear order from offset 10, then wrap.
      drive(1, 0, 16'h1232, 0, "R2 load linear");
      drive(0, 1, 16'h0000, 0, "R5 beat1");
      drive(0, 1, 16'h0000, 0, "R5 beat2");
      drive(0, 1, 16'h0000, 0, "R5 R8 beat3 last");
      drive(0, 0, 16'hFFFF, 0, "R4 hold");
      drive(0, 0, 16'hABCD, 0, "R10 start ignored without load");
      drive(0, 1, 16'h0000, 0, "R9 wrap linear");

      // Every start in both orders; four beats and a wrap.
      for (int md = 0; md < 2; md++) begin
         for (int s = 0; s < 4; s++) begin
            drive(1, 0, {14'h2A5C + 14'(s), 2'(s)}, 1'(md), "R2 load");
            for (int b = 1; b < 4; b++)
               drive(0, 1, 16'h0000, 1'(md), md ? "R6 R7 R8 interleave beat" : "R5 R7 R8 linear beat");
            drive(0, 1, 16'h0000, 1'(md), "R9 wrap to start");
         end
      end

      // Load and advance together, on the last beat.
      drive(1, 0, 16'h4441, 1, "R2 load");
      drive(0, 1, 16'h0000, 1, "R6 beat1");
      drive(0, 1, 16'h0000, 1, "R6 beat2");
      drive(0, 1, 16'h0000, 1, "R8 beat3 last");
      drive(1, 1, 16'h7773, 1, "R3 load wins over advance");
      drive(0, 1, 16'h0000, 1, "R3 count restarted");

      // Reset in the middle of a burst.
      drive(0, 1, 16'h0000, 1, "R6 beat2");
      @(negedge clk);
      rst_ni = 1'b0;
      adv_i  = 1'b0;
      repeat (2) @(negedge clk);
      rst_ni  = 1'b1;
      m_start = '0;
      m_cnt   = 0;
      drive(0, 0, 16'h0000, 1, "R1 reset mid-burst");

      drive(0, 0, 16'h0000, 1, "R4 idle");
      while (sb_q.size() > 0) @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule